// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block sits on a microcontroller's external bus and turns each bus cycle into active-low select strobes for external memories and peripherals. A small write-only register interface holds one base register and one option register for each select, a set of pin-assignment fields and a port data latch. For every access the unit compares the upper address bits against each programmed block. It checks the transfer direction, the active byte lanes and the data-strobe condition. On a match it pulls the select pin low while the address strobe is valid.

Each of the twelve output pins is routed by a 2-bit assignment code. The code makes the pin a select with an 8-bit or 16-bit port, a discrete output driven from the port latch, or a passthrough of an alternate-function signal that comes from elsewhere on the chip. When an access starts and a select matches, a down-counter inserts that select's wait states. It then pulses an acknowledge that also reports the port width. Select 0 is the boot select: it leaves reset enabled over the lowest megabyte with the longest counted wait, so a startup program can be fetched before software has configured anything.

Top module: `csel_unit`

## Requirements
- R1: While reset is held, every pin output reads 1. After reset, select 0 is a 16-bit select over addresses 0x000000 to 0x0FFFFF. It allows reads and writes on both byte lanes with 14 wait states. Every other pin carries its alternate-function input, and no other select can match.
- R2: A base register holds address bits 23..11 in its bits 15..3 and a block-size code in bits 2..0. Codes 0 to 7 give blocks of 2K, 8K, 16K, 64K, 128K, 256K, 512K and 1M bytes. Only the address bits at or above the block size are compared with the base.
- R3: Option bit 0 permits reads and option bit 1 permits writes (bus_rd=1 is a read). A select pin is driven low only in the cycle after an edge at which bus_as was high and the select matched. With bus_as low, every pin assigned as a select reads 1 after the next edge.
- R4: Option bit 2 enables the lower byte lane and option bit 3 the upper one. A select matches only if at least one enabled lane is active in the access (bus_lb, bus_ub).
- R5: When option bit 4 is set, the select additionally requires bus_ds high. When it is clear, bus_ds is ignored.
- R6: Option bits 8..5 hold a wait count W. Take E0 as the first edge at which bus_as is high after an edge with it low. If some select matches at E0, a one-cycle acknowledge appears after edge E0+W, as long as bus_as stays high through that edge. W=15 gives no acknowledge, and dropping bus_as before E0+W cancels it.
- R7: The acknowledge is ack16 when the matching pin's code is 3 and ack8 when it is 2. The two never assert together.
- R8: Pin-assignment register 0x20 holds pins 0..5 and register 0x21 holds pins 6..11, with pin 6r+j in bits 2j+1..2j of register 0x20+r. Base registers sit at 0x00+i and option registers at 0x10+i (bits 8..0). The port latch sits at 0x30 (bit i for pin i). A write takes effect from the next cycle.
- R9: Code 0 on a pin that has a discrete output (pins 1..7 by default) drives the port latch bit. Code 0 on any other pin, and code 1 on any pin, passes that pin's alt_in. All pin outputs are registered one cycle.
- R10: A select whose pin is not assigned code 2 or 3 never matches: its pin carries no select and it produces no acknowledge.
- R11: When several selects match one access, all their pins go low. The wait count and port width are taken from the lowest-numbered matching select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register write address |
| reg_wdata | input | 16 | Register write data |
| bus_as | input | 1 | Address strobe, high while the address is valid |
| bus_addr_hi | input | 13 | Bus address bits 23..11 |
| bus_rd | input | 1 | 1 for a read, 0 for a write |
| bus_ub | input | 1 | Upper byte lane active |
| bus_lb | input | 1 | Lower byte lane active |
| bus_ds | input | 1 | Data strobe valid |
| alt_in | input | 12 | Alternate-function value for each pin |
| pin_out | output | 12 | Registered pin outputs (selects active low) |
| ack8 | output | 1 | Acknowledge from an 8-bit port |
| ack16 | output | 1 | Acknowledge from a 16-bit port |

## Verification
The properties assume that bus_as is low for at least one edge between accesses. They also assume that the address, direction, lanes and configuration stay steady while an access runs. The bench keeps to this by changing registers only between accesses, setting every bus input at a falling edge together with the strobe, and always inserting an idle edge after it drops the strobe. Random rounds reprogram every select with random bases, sizes, options and pin codes, so overlapping and non-matching blocks both occur. Each access is then aimed inside a chosen block or at a random address, with random lanes, direction, data strobe and strobe length.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int MIN_LOG2  = 11;
  localparam int OPT_W     = 9;
  localparam int WAIT_W    = 4;
  localparam logic [WAIT_W-1:0] WAIT_NOACK = '1;

  localparam logic [5:0] BASE_OFS = 6'h00;
  localparam logic [5:0] OPT_OFS  = 6'h10;
  localparam logic [5:0] PIN_OFS  = 6'h20;
  localparam logic [5:0] PORT_OFS = 6'h30;
  localparam int FIELDS_PER_REG   = 6;

  typedef enum logic [1:0] {
    PIN_DISC = 2'd0,
    PIN_ALT  = 2'd1,
    PIN_CS8  = 2'd2,
    PIN_CS16 = 2'd3
  } pin_code_e;

  // boot select: 14 waits, data strobe ignored, both lanes, read and write
  localparam logic [OPT_W-1:0] BOOT_OPT = 9'h1CF;
  localparam logic [2:0] BOOT_SIZE = 3'd7;

  // number of address bits above MIN_LOG2 left out of the compare
  function automatic logic [3:0] size_span(input logic [2:0] code);
    case (code)
      3'd0: return 4'd0;
      3'd1: return 4'd2;
      3'd2: return 4'd3;
      3'd3: return 4'd5;
      3'd4: return 4'd6;
      3'd5: return 4'd7;
      3'd6: return 4'd8;
      default: return 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int NUM_SEL = 12,
  parameter int REG_W   = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              reg_we,
  input  logic [5:0]                        reg_addr,
  input  logic [REG_W-1:0]                  reg_wdata,
  output logic [NUM_SEL-1:0][REG_W-1:0]     base_q,
  output logic [NUM_SEL-1:0][OPT_W-1:0]     opt_q,
  output logic [NUM_SEL-1:0][1:0]           pin_q,
  output logic [NUM_SEL-1:0]                port_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEL; i++) begin
        base_q[i] <= '0;
        opt_q[i]  <= '0;
        pin_q[i]  <= PIN_ALT;
      end
      base_q[0] <= {{(REG_W-3){1'b0}}, BOOT_SIZE};
      opt_q[0]  <= BOOT_OPT;
      pin_q[0]  <= PIN_CS16;
      port_q    <= '0;
    end else if (reg_we) begin
      for (int i = 0; i < NUM_SEL; i++) begin
        if (reg_addr == BASE_OFS + 6'(i)) base_q[i] <= reg_wdata;
        if (reg_addr == OPT_OFS + 6'(i))  opt_q[i]  <= reg_wdata[OPT_W-1:0];
        if (reg_addr == PIN_OFS + 6'(i / FIELDS_PER_REG))
          pin_q[i] <= reg_wdata[2*(i % FIELDS_PER_REG) +: 2];
      end
      if (reg_addr == PORT_OFS) port_q <= reg_wdata[NUM_SEL-1:0];
    end
  end
endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
#(
  parameter int HI_W = 13
) (
  input  logic [HI_W-1:0]  addr_hi,
  input  logic [HI_W+2:0]  base,
  input  logic [OPT_W-1:0] opt,
  input  logic             pin_cs,
  input  logic             bus_rd,
  input  logic             bus_ub,
  input  logic             bus_lb,
  input  logic             bus_ds,
  output logic             hit
);
  logic [3:0] span;
  logic addr_ok, rw_ok, lane_ok, ds_ok;

  always_comb begin
    span    = size_span(base[2:0]);
    addr_ok = 1'b1;
    for (int b = 0; b < HI_W; b++) begin
      if (b >= int'(span) && addr_hi[b] != base[b+3]) addr_ok = 1'b0;
    end
  end

  assign rw_ok   = bus_rd ? opt[0] : opt[1];
  assign lane_ok = (opt[2] & bus_lb) | (opt[3] & bus_ub);
  assign ds_ok   = ~opt[4] | bus_ds;
  assign hit     = pin_cs & addr_ok & rw_ok & lane_ok & ds_ok;
endmodule

// File: rtl/csel_wait.sv
module csel_wait
  import csel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              start,
  input  logic [WAIT_W-1:0] start_wait,
  input  logic              start_wide,
  output logic              ack8,
  output logic              ack16
);
  logic              busy;
  logic              wide_q;
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      wide_q <= 1'b0;
      cnt    <= '0;
      ack8   <= 1'b0;
      ack16  <= 1'b0;
    end else begin
      ack8  <= 1'b0;
      ack16 <= 1'b0;
      if (!strobe) begin
        busy <= 1'b0;
      end else if (start) begin
        wide_q <= start_wide;
        if (start_wait == WAIT_NOACK) begin
          busy <= 1'b0;
        end else if (start_wait == '0) begin
          busy  <= 1'b0;
          ack8  <= ~start_wide;
          ack16 <= start_wide;
        end else begin
          busy <= 1'b1;
          cnt  <= start_wait - 1'b1;
        end
      end else if (busy) begin
        if (cnt == '0) begin
          busy  <= 1'b0;
          ack8  <= ~wide_q;
          ack16 <= wide_q;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int NUM_SEL            = 12,
  parameter int ADDR_W             = 24,
  parameter logic [NUM_SEL-1:0] DISC_MASK = 12'h0FE,
  localparam int HI_W              = ADDR_W - MIN_LOG2,
  localparam int REG_W             = HI_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [5:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic               bus_as,
  input  logic [HI_W-1:0]    bus_addr_hi,
  input  logic               bus_rd,
  input  logic               bus_ub,
  input  logic               bus_lb,
  input  logic               bus_ds,
  input  logic [NUM_SEL-1:0] alt_in,
  output logic [NUM_SEL-1:0] pin_out,
  output logic               ack8,
  output logic               ack16
);
  logic [NUM_SEL-1:0][REG_W-1:0] base_q;
  logic [NUM_SEL-1:0][OPT_W-1:0] opt_q;
  logic [NUM_SEL-1:0][1:0]       pin_q;
  logic [NUM_SEL-1:0]            port_q;
  logic [NUM_SEL-1:0]            hit;
  logic [NUM_SEL-1:0]            cs_cfg;
  logic                          strobe_q;
  logic                          start;
  logic [WAIT_W-1:0]             sel_wait;
  logic                          sel_wide;

  csel_regs #(.NUM_SEL(NUM_SEL), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .base_q(base_q), .opt_q(opt_q),
    .pin_q(pin_q), .port_q(port_q)
  );

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign cs_cfg[g] = pin_q[g][1];

    csel_match #(.HI_W(HI_W)) u_match (
      .addr_hi(bus_addr_hi), .base(base_q[g]), .opt(opt_q[g]),
      .pin_cs(cs_cfg[g]), .bus_rd(bus_rd), .bus_ub(bus_ub),
      .bus_lb(bus_lb), .bus_ds(bus_ds), .hit(hit[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[g] <= 1'b1;
      end else begin
        case (pin_q[g])
          PIN_CS8, PIN_CS16: pin_out[g] <= ~(hit[g] & bus_as);
          PIN_DISC:          pin_out[g] <= DISC_MASK[g] ? port_q[g] : alt_in[g];
          default:           pin_out[g] <= alt_in[g];
        endcase
      end
    end
  end

  // lowest-numbered matching select supplies wait count and width
  always_comb begin
    sel_wait = WAIT_NOACK;
    sel_wide = 1'b0;
    for (int i = NUM_SEL - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_wait = opt_q[i][8:5];
        sel_wide = (pin_q[i] == PIN_CS16);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= bus_as;
  end

  assign start = bus_as & ~strobe_q & (|hit);

  csel_wait u_wait (
    .clk(clk), .rst(rst), .strobe(bus_as), .start(start),
    .start_wait(sel_wait), .start_wide(sel_wide),
    .ack8(ack8), .ack16(ack16)
  );
endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
  parameter int NUM_SEL = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_as,
  input logic [NUM_SEL-1:0] pin_out,
  input logic [NUM_SEL-1:0] cs_cfg,
  input logic               ack8,
  input logic               ack16
);
  // R7
  ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ack8 && ack16));

  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (ack8 || ack16) |=> !(ack8 || ack16));

  // R6
  ack_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (ack8 || ack16) |-> $past(bus_as));

  // R3
  strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_as |=> ((pin_out & $past(cs_cfg)) == $past(cs_cfg)));

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '1 && !ack8 && !ack16));
endmodule

bind csel_unit csel_unit_chk #(.NUM_SEL(NUM_SEL)) u_chk (
  .clk(clk), .rst(rst), .bus_as(bus_as), .pin_out(pin_out),
  .cs_cfg(cs_cfg), .ack8(ack8), .ack16(ack16)
);

// File: tb/csel_unit_tb.sv
module csel_unit_tb;
  localparam int N = 12;
  localparam logic [N-1:0] DISC = 12'h0FE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic bus_as = 1'b0, bus_rd = 1'b1, bus_ub = 1'b0, bus_lb = 1'b0, bus_ds = 1'b0;
  logic [12:0] bus_addr_hi = '0;
  logic [N-1:0] alt_in = 12'hA5A;
  logic [N-1:0] pin_out;
  logic ack8, ack16;

  int total = 0, bad = 0;
  bit done = 0;

  logic [15:0] b_base [N];
  logic [8:0]  b_opt  [N];
  logic [1:0]  b_pin  [N];
  logic [N-1:0] b_port;

  always #4 clk = ~clk;

  csel_unit u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bus_as(bus_as), .bus_addr_hi(bus_addr_hi),
    .bus_rd(bus_rd), .bus_ub(bus_ub), .bus_lb(bus_lb), .bus_ds(bus_ds),
    .alt_in(alt_in), .pin_out(pin_out), .ack8(ack8), .ack16(ack16)
  );

  function automatic int blk_log2(input logic [2:0] c);
    int t [8] = '{11, 13, 14, 16, 17, 18, 19, 20};
    return t[c];
  endfunction

  function automatic bit m_hit(input int i, input logic [23:0] a,
                               input bit rd, ub, lb, ds);
    int s;
    logic [23:0] base_a;
    s = blk_log2(b_base[i][2:0]);
    base_a = {b_base[i][15:3], 11'b0};
    if (!b_pin[i][1]) return 0;
    if ((a >> s) != (base_a >> s)) return 0;
    if (rd && !b_opt[i][0]) return 0;
    if (!rd && !b_opt[i][1]) return 0;
    if (!((lb && b_opt[i][2]) || (ub && b_opt[i][3]))) return 0;
    if (b_opt[i][4] && !ds) return 0;
    return 1;
  endfunction

  function automatic logic [N-1:0] m_pins(input logic [23:0] a,
      input bit as, rd, ub, lb, ds);
    logic [N-1:0] p;
    for (int i = 0; i < N; i++) begin
      if (b_pin[i][1])                   p[i] = !(as && m_hit(i, a, rd, ub, lb, ds));
      else if (b_pin[i] == 0 && DISC[i]) p[i] = b_port[i];
      else                               p[i] = alt_in[i];
    end
    return p;
  endfunction

  // packed as {wide, cycle}; 'hFFFF means no acknowledge
  function automatic logic [31:0] m_ack(input logic [23:0] a,
      input bit rd, ub, lb, ds, input int hold);
    for (int i = 0; i < N; i++) begin
      if (m_hit(i, a, rd, ub, lb, ds)) begin
        int w;
        w = int'(b_opt[i][8:5]);
        if (w == 15 || w >= hold) return 32'hFFFF;
        return ((b_pin[i] == 2'd3) ? 32'h100 : 32'h0) | w;
      end
    end
    return 32'hFFFF;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] ad, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ad; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_base(input int i, input logic [23:0] a, input logic [2:0] c);
    b_base[i] = {a[23:11], c};
    wr(6'h00 + 6'(i), b_base[i]);
  endtask

  task automatic set_opt(input int i, input logic [8:0] v);
    b_opt[i] = v;
    wr(6'h10 + 6'(i), {7'b0, v});
  endtask

  task automatic set_pin(input int i, input logic [1:0] c);
    logic [15:0] w;
    int r;
    b_pin[i] = c;
    r = i / 6;
    w = '0;
    for (int j = 0; j < 6; j++) w[2*j +: 2] = b_pin[6*r + j];
    wr(6'h20 + 6'(r), w);
  endtask

  task automatic set_port(input logic [N-1:0] v);
    b_port = v;
    wr(6'h30, {4'b0, v});
  endtask

  task automatic access(input string tag, input logic [23:0] a,
                        input bit rd, ub, lb, ds, input int hold);
    logic [N-1:0] ep, gp;
    logic [31:0] ea, ga;
    int gk, nack;
    bit gw, pbad;
    ep = m_pins(a, 1, rd, ub, lb, ds);
    ea = m_ack(a, rd, ub, lb, ds, hold);
    @(negedge clk);
    bus_addr_hi = a[23:11]; bus_rd = rd; bus_ub = ub; bus_lb = lb;
    bus_ds = ds; bus_as = 1'b1;
    gk = -1; nack = 0; gw = 0; pbad = 0; gp = ep;
    for (int k = 0; k < hold; k++) begin
      @(posedge clk); #1;
      if (pin_out !== ep) begin pbad = 1; gp = pin_out; end
      if (ack8 || ack16) begin
        nack++;
        if (gk < 0) begin gk = k; gw = ack16; end
      end
    end
    @(negedge clk);
    bus_as = 1'b0;
    @(posedge clk); #1;
    if (ack8 || ack16) nack++;
    if (nack > 1)     ga = 32'hEEEE;
    else if (gk < 0)  ga = 32'hFFFF;
    else              ga = (gw ? 32'h100 : 32'h0) | gk;
    check(tag, "pins", {20'b0, pbad ? gp : ep}, {20'b0, ep});
    check(tag, "ack", ga, ea);
    check(tag, "idle pins", {20'b0, pin_out}, {20'b0, m_pins(a, 0, rd, ub, lb, ds)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin
      b_base[i] = '0; b_opt[i] = '0; b_pin[i] = 2'd1;
    end
    b_base[0] = 16'h0007; b_opt[0] = 9'h1CF; b_pin[0] = 2'd3; b_port = '0;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1 check("R1", "pins in reset", {20'b0, pin_out}, 32'hFFF);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check("R1", "pins after reset", {20'b0, pin_out}, {20'b0, m_pins(0, 0, 1, 1, 1, 0)});
    access("R1", 24'h0F_0000, 1, 1, 1, 0, 16);
    access("R1", 24'h00_1234, 0, 0, 1, 0, 16);

    // R2: block size and upper-bit compare
    access("R2", 24'h10_0000, 1, 1, 1, 0, 16);
    set_base(1, 24'h20_0000, 3'd0);
    set_opt(1, 9'h04D);
    set_pin(1, 2'd2);
    access("R2", 24'h20_07FF, 1, 1, 1, 0, 6);
    access("R2", 24'h20_0800, 1, 1, 1, 0, 6);
    set_base(1, 24'h20_0000, 3'd3);
    access("R2", 24'h20_F000, 1, 1, 1, 0, 6);
    access("R2", 24'h21_0000, 1, 1, 1, 0, 6);

    // R3: read/write qualifier
    access("R3", 24'h20_0010, 0, 1, 1, 0, 6);
    set_opt(1, 9'h04E);
    access("R3", 24'h20_0010, 0, 1, 1, 0, 6);
    access("R3", 24'h20_0010, 1, 1, 1, 0, 6);

    // R4: byte lanes
    set_opt(1, 9'h049);
    access("R4", 24'h20_0020, 1, 0, 1, 0, 6);
    access("R4", 24'h20_0020, 1, 1, 0, 0, 6);

    // R5: data strobe qualifier
    set_opt(1, 9'h05D);
    access("R5", 24'h20_0030, 1, 1, 1, 0, 6);
    access("R5", 24'h20_0030, 1, 1, 1, 1, 6);

    // R6: wait counts, no-ack code, early strobe drop
    set_opt(1, 9'h1ED);
    access("R6", 24'h20_0040, 1, 1, 1, 0, 18);
    set_opt(1, 9'h00D);
    access("R6", 24'h20_0040, 1, 1, 1, 0, 3);
    set_opt(1, 9'h12D);
    access("R6", 24'h20_0040, 1, 1, 1, 0, 5);
    access("R6", 24'h20_0040, 1, 1, 1, 0, 10);

    // R7: port width
    set_opt(1, 9'h06D);
    set_pin(1, 2'd3);
    access("R7", 24'h20_0050, 1, 1, 1, 0, 6);

    // R9: discrete outputs and alternate fallback
    set_pin(3, 2'd0);
    set_pin(9, 2'd0);
    set_port(12'h208);
    access("R9", 24'h30_0000, 1, 1, 1, 0, 2);
    set_port(12'h000);
    @(negedge clk) alt_in = 12'h5A5;
    access("R9", 24'h30_0000, 1, 1, 1, 0, 2);

    // R10: select without select pin code
    set_base(2, 24'h40_0000, 3'd3);
    set_opt(2, 9'h02F);
    access("R10", 24'h40_1234, 1, 1, 1, 0, 6);
    set_pin(2, 2'd2);
    access("R10", 24'h40_1234, 1, 1, 1, 0, 6);

    // R8: field placement in the second assignment register
    set_base(8, 24'h60_0000, 3'd1);
    set_opt(8, 9'h04F);
    access("R8", 24'h60_0100, 1, 1, 1, 0, 6);
    set_pin(8, 2'd3);
    access("R8", 24'h60_0100, 1, 1, 1, 0, 6);

    // R11: overlapping selects
    set_base(4, 24'h80_0000, 3'd7);
    set_base(5, 24'h84_0000, 3'd3);
    set_opt(4, 9'h0AF);
    set_opt(5, 9'h04F);
    set_pin(4, 2'd2);
    set_pin(5, 2'd3);
    access("R11", 24'h84_0100, 1, 1, 1, 0, 8);
    access("R11", 24'h90_0000, 1, 1, 1, 0, 8);

    // R2 R11 random rounds
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++) begin
        set_base(i, 24'($urandom), 3'($urandom));
        set_opt(i, 9'($urandom));
        set_pin(i, 2'($urandom));
      end
      set_port(12'($urandom));
      @(negedge clk) alt_in = 12'($urandom);
      for (int k = 0; k < 25; k++) begin
        int j, s;
        logic [23:0] a;
        j = int'($urandom % N);
        s = blk_log2(b_base[j][2:0]);
        a = {b_base[j][15:3], 11'b0} | (24'($urandom) & ((24'd1 << s) - 24'd1));
        if ($urandom % 4 == 0) a = 24'($urandom);
        access("R11", a, 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), 1 + int'($urandom % 18));
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule